// File: doc/BRIEF.md
# Test Access Port Instruction and Data Register Path

This block sits behind a test access port state controller and owns everything that moves bits between the serial input and the serial output. It has an instruction shift stage with a separate instruction holding register. It decodes the held instruction into a data-register select. It also holds the data registers that belong to the port itself: a one-bit pass-through register and a 32-bit identification register. A third data register lives outside the block and is reached through a gated strobe port.

The controller supplies one level signal per relevant state: reset, the capture, shift and update phases for the instruction, and the same three phases for data. On each rising test clock edge the selected stage captures, shifts or updates. The serial output is retimed on the falling edge and enabled only while a shift phase is active. After reset the held instruction selects the identification register, or the pass-through register when identification is built out. A host can then size the chain from the leading bits it reads back.

Top module: `tapdr_path`

## Requirements
- R1: While asynchronous reset is low, or on any rising edge with the reset-state strobe high, the held instruction becomes the identification opcode (5'h01 by default); with identification disabled it becomes all ones.
- R2: A rising edge with the instruction-capture strobe high loads the instruction shift stage with 1 in bit 0 and 0 in every other bit, whatever instruction is held.
- R3: The all-ones opcode selects the pass-through register, which is one bit long and captures 0.
- R4: The identification opcode selects a 32-bit register that captures version in bits 31:28 (default 4'h3), part number in bits 27:12 (default 16'hB7C1), manufacturer in bits 11:1 (default 11'h23A) and 1 in bit 0.
- R5: Any opcode other than the identification and external opcodes selects the pass-through register.
- R6: In a shift phase each rising edge moves the selected stage one bit from the serial input toward the serial output, bit 0 leaving first, so the path length is 5 bits for instructions and 1, 32 or the external length for data, per the held instruction.
- R7: The held instruction changes only on an instruction-update or reset-state edge; shifting a new opcode without an update leaves the data selection unchanged.
- R8: The serial output and its enable change only on falling test clock edges; the enable is high only after a falling edge that saw a shift strobe, and both are low in reset.
- R9: The external opcode (5'h08 by default) raises the external select, passes the data capture, shift and update strobes to the external register and takes the serial output from its return bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous reset, active low |
| tdi | input | 1 | Serial data in |
| st_reset | input | 1 | Controller is in the reset state |
| st_cap_ir | input | 1 | Instruction capture phase |
| st_shift_ir | input | 1 | Instruction shift phase |
| st_upd_ir | input | 1 | Instruction update phase |
| st_cap_dr | input | 1 | Data capture phase |
| st_shift_dr | input | 1 | Data shift phase |
| st_upd_dr | input | 1 | Data update phase |
| xdr_tdo | input | 1 | Serial return from the external data register |
| xdr_sel | output | 1 | Held instruction selects the external register |
| xdr_capture | output | 1 | Capture strobe for the external register |
| xdr_shift | output | 1 | Shift strobe for the external register |
| xdr_update | output | 1 | Update strobe for the external register |
| tdo | output | 1 | Serial data out, falling-edge timed |
| tdo_oe | output | 1 | Output enable for tdo |

## Verification
The bench sizes the path the way a host does, by reading back 48 bits and checking where its own input bits reappear. A design with the wrong register length, or one that shifts from the wrong end, shows those bits at the wrong offset. An opcode is shifted in without an update to catch a design that lets the shift stage leak into the held instruction. The reset-state strobe is pulsed mid-run to catch a design that only resets asynchronously. The serial output is sampled just after a rising edge inside a shift, so a design that retimes on the rising edge shows the next bit half a cycle early. Unknown opcodes drawn at random must all fall back to the pass-through register; a decoder that treats them otherwise returns a wrong length.

// File: rtl/tapdr_pkg.sv
package tapdr_pkg;
   typedef enum logic [1:0] {
      DSEL_PASS = 2'd0,
      DSEL_IDENT = 2'd1,
      DSEL_EXT = 2'd2
   } dsel_e;
endpackage

// File: rtl/tapdr_instr.sv
module tapdr_instr
   import tapdr_pkg::*;
#(
   parameter int IR_W = 5,
   parameter logic [IR_W-1:0] OP_IDENT = 5'h01,
   parameter logic [IR_W-1:0] OP_EXT = 5'h08,
   parameter bit HAS_IDENT = 1'b1
) (
   input  logic tck,
   input  logic trst_n,
   input  logic tdi,
   input  logic st_reset,
   input  logic st_cap_ir,
   input  logic st_shift_ir,
   input  logic st_upd_ir,
   output logic ir_tdo,
   output dsel_e dsel
);
   localparam logic [IR_W-1:0] CAP_PAT = 1;
   localparam logic [IR_W-1:0] RST_OP = HAS_IDENT ? OP_IDENT : {IR_W{1'b1}};

   logic [IR_W-1:0] sh_q;
   logic [IR_W-1:0] hold_q;

   initial begin
      assert (IR_W >= 2) else $error("instruction width below 2");
      assert (OP_EXT != {IR_W{1'b1}}) else $error("external opcode clashes with pass-through");
      assert (!HAS_IDENT || OP_IDENT != {IR_W{1'b1}}) else $error("identification opcode clashes with pass-through");
      assert (!HAS_IDENT || OP_IDENT != OP_EXT) else $error("identification and external opcodes equal");
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) sh_q <= CAP_PAT;
      else if (st_cap_ir) sh_q <= CAP_PAT;
      else if (st_shift_ir) sh_q <= {tdi, sh_q[IR_W-1:1]};
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) hold_q <= RST_OP;
      else if (st_reset) hold_q <= RST_OP;
      else if (st_upd_ir) hold_q <= sh_q;
   end

   assign ir_tdo = sh_q[0];

   generate
      if (HAS_IDENT) begin : g_dec_ident
         always_comb begin
            if (hold_q == OP_IDENT) dsel = DSEL_IDENT;
            else if (hold_q == OP_EXT) dsel = DSEL_EXT;
            else dsel = DSEL_PASS;
         end
      end else begin : g_dec_plain
         always_comb begin
            if (hold_q == OP_EXT) dsel = DSEL_EXT;
            else dsel = DSEL_PASS;
         end
      end
   endgenerate

   AST_CAP_PATTERN: assert property (@(posedge tck) disable iff (!trst_n)
      st_cap_ir |=> (sh_q == CAP_PAT)); // R2
   AST_HOLD_STABLE: assert property (@(posedge tck) disable iff (!trst_n)
      (!st_upd_ir && !st_reset) |=> $stable(hold_q)); // R7
   AST_RESET_LOAD: assert property (@(posedge tck) disable iff (!trst_n)
      st_reset |=> (hold_q == RST_OP)); // R1
   AST_ONES_PASS: assert property (@(posedge tck) disable iff (!trst_n)
      (hold_q == {IR_W{1'b1}}) |-> (dsel == DSEL_PASS)); // R3
endmodule

// File: rtl/tapdr_pass.sv
module tapdr_pass (
   input  logic tck,
   input  logic trst_n,
   input  logic tdi,
   input  logic cap,
   input  logic shift,
   output logic pass_tdo
);
   logic bit_q;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) bit_q <= 1'b0;
      else if (cap) bit_q <= 1'b0;
      else if (shift) bit_q <= tdi;
   end

   assign pass_tdo = bit_q;

   AST_PASS_ZERO: assert property (@(posedge tck) disable iff (!trst_n)
      cap |=> !bit_q); // R3
endmodule

// File: rtl/tapdr_ident.sv
module tapdr_ident #(
   parameter bit HAS_IDENT = 1'b1,
   parameter logic [3:0] VERSION = 4'h3,
   parameter logic [15:0] PART = 16'hB7C1,
   parameter logic [10:0] MAKER = 11'h23A
) (
   input  logic tck,
   input  logic trst_n,
   input  logic tdi,
   input  logic cap,
   input  logic shift,
   output logic id_tdo
);
   localparam int ID_W = 32;
   localparam logic [ID_W-1:0] ID_VAL = {VERSION, PART, MAKER, 1'b1};

   generate
      if (HAS_IDENT) begin : g_ident
         logic [ID_W-1:0] sr_q;
         always_ff @(posedge tck or negedge trst_n) begin
            if (!trst_n) sr_q <= ID_VAL;
            else if (cap) sr_q <= ID_VAL;
            else if (shift) sr_q <= {tdi, sr_q[ID_W-1:1]};
         end
         assign id_tdo = sr_q[0];

         AST_IDENT_CAPTURE: assert property (@(posedge tck) disable iff (!trst_n)
            cap |=> (sr_q == ID_VAL) && sr_q[0]); // R4
      end else begin : g_none
         assign id_tdo = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/tapdr_path.sv
module tapdr_path
   import tapdr_pkg::*;
#(
   parameter int IR_W = 5,
   parameter logic [IR_W-1:0] OP_IDENT = 5'h01,
   parameter logic [IR_W-1:0] OP_EXT = 5'h08,
   parameter bit HAS_IDENT = 1'b1,
   parameter logic [3:0] VERSION = 4'h3,
   parameter logic [15:0] PART = 16'hB7C1,
   parameter logic [10:0] MAKER = 11'h23A
) (
   input  logic tck,
   input  logic trst_n,
   input  logic tdi,
   input  logic st_reset,
   input  logic st_cap_ir,
   input  logic st_shift_ir,
   input  logic st_upd_ir,
   input  logic st_cap_dr,
   input  logic st_shift_dr,
   input  logic st_upd_dr,
   input  logic xdr_tdo,
   output logic xdr_sel,
   output logic xdr_capture,
   output logic xdr_shift,
   output logic xdr_update,
   output logic tdo,
   output logic tdo_oe
);
   dsel_e dsel;
   logic ir_tdo, pass_tdo, id_tdo, dr_tdo, src;
   logic sel_pass, sel_id;

   tapdr_instr #(.IR_W(IR_W), .OP_IDENT(OP_IDENT), .OP_EXT(OP_EXT), .HAS_IDENT(HAS_IDENT)) u_instr (
      .tck(tck), .trst_n(trst_n), .tdi(tdi),
      .st_reset(st_reset), .st_cap_ir(st_cap_ir), .st_shift_ir(st_shift_ir), .st_upd_ir(st_upd_ir),
      .ir_tdo(ir_tdo), .dsel(dsel));

   assign sel_pass = (dsel == DSEL_PASS);
   assign sel_id = (dsel == DSEL_IDENT);
   assign xdr_sel = (dsel == DSEL_EXT);

   tapdr_pass u_pass (
      .tck(tck), .trst_n(trst_n), .tdi(tdi),
      .cap(st_cap_dr && sel_pass), .shift(st_shift_dr && sel_pass), .pass_tdo(pass_tdo));

   tapdr_ident #(.HAS_IDENT(HAS_IDENT), .VERSION(VERSION), .PART(PART), .MAKER(MAKER)) u_ident (
      .tck(tck), .trst_n(trst_n), .tdi(tdi),
      .cap(st_cap_dr && sel_id), .shift(st_shift_dr && sel_id), .id_tdo(id_tdo));

   assign xdr_capture = st_cap_dr && xdr_sel;
   assign xdr_shift = st_shift_dr && xdr_sel;
   assign xdr_update = st_upd_dr && xdr_sel;

   always_comb begin
      unique case (dsel)
         DSEL_IDENT: dr_tdo = id_tdo;
         DSEL_EXT: dr_tdo = xdr_tdo;
         default: dr_tdo = pass_tdo;
      endcase
   end

   assign src = st_shift_ir ? ir_tdo : dr_tdo;

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         tdo <= 1'b0;
         tdo_oe <= 1'b0;
      end else begin
         tdo <= src;
         tdo_oe <= st_shift_ir || st_shift_dr;
      end
   end

   AST_OE_IDLE: assert property (@(negedge tck) disable iff (!trst_n)
      (!st_shift_ir && !st_shift_dr) |=> !tdo_oe); // R8
   AST_EXT_QUIET: assert property (@(posedge tck) disable iff (!trst_n)
      !xdr_sel |-> !(xdr_capture || xdr_shift || xdr_update)); // R9
endmodule

// File: tb/sim_tapdr_path.sv
module sim_tapdr_path;
   localparam logic [4:0] OP_ID = 5'h01;
   localparam logic [4:0] OP_EXT = 5'h08;
   localparam logic [31:0] IDV = {4'h3, 16'hB7C1, 11'h23A, 1'b1};
   localparam logic [6:0] S_TLR = 7'd1, S_CIR = 7'd2, S_SIR = 7'd4, S_UIR = 7'd8,
                          S_CDR = 7'd16, S_SDR = 7'd32, S_UDR = 7'd64;

   logic tck = 1'b0;
   always #2 tck = ~tck;

   logic trst_n = 1'b0;
   logic tdi = 1'b0;
   logic [6:0] st = 7'd0;
   logic xdr_tdo, xdr_sel, xdr_capture, xdr_shift, xdr_update, tdo, tdo_oe;
   logic [7:0] ext_sr;

   tapdr_path u0 (
      .tck(tck), .trst_n(trst_n), .tdi(tdi),
      .st_reset(st[0]), .st_cap_ir(st[1]), .st_shift_ir(st[2]), .st_upd_ir(st[3]),
      .st_cap_dr(st[4]), .st_shift_dr(st[5]), .st_upd_dr(st[6]),
      .xdr_tdo(xdr_tdo), .xdr_sel(xdr_sel), .xdr_capture(xdr_capture),
      .xdr_shift(xdr_shift), .xdr_update(xdr_update), .tdo(tdo), .tdo_oe(tdo_oe));

   always @(posedge tck) begin
      if (xdr_capture) ext_sr <= 8'hA5;
      else if (xdr_shift) ext_sr <= {tdi, ext_sr[7:1]};
   end
   assign xdr_tdo = ext_sr[0];

   int checks = 0;
   int fails = 0;
   bit done = 0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick(input logic [6:0] s, input logic d, output logic o, output logic oe);
      @(posedge tck);
      #1;
      st = s;
      tdi = d;
      #2;
      o = tdo;
      oe = tdo_oe;
   endtask

   task automatic scan_ir(input logic [4:0] op, input bit upd, output logic [4:0] seen, output logic oe_ok);
      logic o, oe;
      tick(S_CIR, 1'b0, o, oe);
      oe_ok = !oe;
      for (int i = 0; i < 5; i++) begin
         tick(S_SIR, op[i], o, oe);
         seen[i] = o;
         oe_ok = oe_ok && oe;
      end
      tick(upd ? S_UIR : 7'd0, 1'b0, o, oe);
      tick(7'd0, 1'b0, o, oe);
   endtask

   task automatic scan_dr(input logic [63:0] din, input int n, output logic [63:0] dout, output logic oe_ok);
      logic o, oe;
      dout = '0;
      tick(S_CDR, 1'b0, o, oe);
      oe_ok = !oe;
      for (int i = 0; i < n; i++) begin
         tick(S_SDR, din[i], o, oe);
         dout[i] = o;
         oe_ok = oe_ok && oe;
      end
      tick(S_UDR, 1'b0, o, oe);
      tick(7'd0, 1'b0, o, oe);
      oe_ok = oe_ok && !oe;
   endtask

   function automatic logic [63:0] exp_dr(input logic [4:0] op, input logic [63:0] din, input int n);
      int len;
      logic [63:0] c, e;
      if (op == OP_ID) begin len = 32; c = {32'h0, IDV}; end
      else if (op == OP_EXT) begin len = 8; c = 64'hA5; end
      else begin len = 1; c = 64'h0; end
      e = '0;
      for (int k = 0; k < n; k++) e[k] = (k < len) ? c[k] : din[k - len];
      return e;
   endfunction

   initial begin
      #400000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [63:0] din, dout;
      logic [4:0] seen;
      logic oe_ok, o, oe, a, b, c;
      logic [4:0] op;
      void'($urandom(32'd2718));

      repeat (3) @(posedge tck);
      #1;
      chk("R8 reset tdo/oe", {62'd0, tdo, tdo_oe}, 64'd0);
      trst_n = 1'b1;

      // R1, R4, R6: identification after reset, fields and offset of returned bits
      din = {$urandom, $urandom};
      scan_dr(din, 48, dout, oe_ok);
      chk("R1 R6 reset selects identification", dout, exp_dr(OP_ID, din, 48));
      chk("R4 version field", {60'd0, dout[31:28]}, 64'h3);
      chk("R4 part field", {48'd0, dout[27:12]}, 64'hB7C1);
      chk("R4 maker field and marker bit", {52'd0, dout[11:0]}, {52'd0, 11'h23A, 1'b1});
      chk("R8 enable only in shift", {63'd0, oe_ok}, 64'd1);

      // R2 capture pattern, R3 all-ones pass-through
      scan_ir(5'h1F, 1'b1, seen, oe_ok);
      chk("R2 capture pattern", {59'd0, seen}, 64'h1);
      din = 64'hFFFF_0000_FFFF_FFFF;
      scan_dr(din, 48, dout, oe_ok);
      chk("R3 all-ones one-bit zero", dout, exp_dr(5'h1F, din, 48));

      // R9 external register
      scan_ir(OP_EXT, 1'b1, seen, oe_ok);
      chk("R9 external select", {63'd0, xdr_sel}, 64'd1);
      din = {$urandom, $urandom};
      scan_dr(din, 48, dout, oe_ok);
      chk("R9 external path", dout, exp_dr(OP_EXT, din, 48));

      // R7 shift without update keeps selection
      scan_ir(OP_ID, 1'b0, seen, oe_ok);
      din = {$urandom, $urandom};
      scan_dr(din, 48, dout, oe_ok);
      chk("R7 no update keeps external", dout, exp_dr(OP_EXT, din, 48));

      // R1 reset-state strobe
      tick(S_TLR, 1'b0, o, oe);
      tick(7'd0, 1'b0, o, oe);
      chk("R1 strobe clears external select", {63'd0, xdr_sel}, 64'd0);
      scan_dr(din, 48, dout, oe_ok);
      chk("R1 strobe restores identification", dout, exp_dr(OP_ID, din, 48));

      // R5 undefined opcode
      scan_ir(5'h13, 1'b1, seen, oe_ok);
      scan_dr(din, 48, dout, oe_ok);
      chk("R5 undefined opcode pass-through", dout, exp_dr(5'h13, din, 48));

      // R8 falling-edge retiming inside an identification shift
      tick(S_TLR, 1'b0, o, oe);
      tick(S_CDR, 1'b0, o, oe);
      @(posedge tck);
      #1;
      st = S_SDR;
      #2;
      a = tdo;
      @(posedge tck);
      #1;
      b = tdo;
      #2;
      c = tdo;
      chk("R8 first bit after falling edge", {63'd0, a}, 64'd1);
      chk("R8 held across rising edge", {63'd0, b}, 64'd1);
      chk("R8 next bit after falling edge", {63'd0, c}, 64'd0);
      tick(S_UDR, 1'b0, o, oe);
      tick(7'd0, 1'b0, o, oe);
      chk("R8 enable low after shift", {63'd0, oe}, 64'd0);

      // random mix
      for (int it = 0; it < 40; it++) begin
         case ($urandom % 4)
            0: op = OP_ID;
            1: op = OP_EXT;
            2: op = 5'h1F;
            default: op = 5'($urandom);
         endcase
         scan_ir(op, 1'b1, seen, oe_ok);
         chk("R2 random capture pattern", {59'd0, seen}, 64'h1);
         chk("R8 random ir enable", {63'd0, oe_ok}, 64'd1);
         din = {$urandom, $urandom};
         scan_dr(din, 48, dout, oe_ok);
         chk("R5 R6 random data path", dout, exp_dr(op, din, 48));
         chk("R8 random dr enable", {63'd0, oe_ok}, 64'd1);
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule